// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch at a given fetch address will be taken. It runs two direction predictors side by side and lets a third table decide which one to trust. The first predictor keys a table of 2-bit saturating counters on a 12-bit record of the most recent branch outcomes seen by the whole machine. The second works in two levels: the fetch address selects a 10-bit outcome record kept for that address, and that record selects a 3-bit saturating counter. The arbiter is a table of 2-bit counters, also keyed on the machine-wide record, which learns for each history pattern which of the two predictors tends to be right.

The predict side is purely combinational. A PC goes in, and the direction comes out in the same cycle, along with the two history values used to form it. The front end keeps those history values with the branch. When the branch resolves, the back end returns the PC, the real outcome and the saved history values on the update port. One update is applied per clock edge. On that edge the outcome shifts into the machine-wide history and into the per-address history, and the counter tables train.

Top module: `tourn_predictor`

## Requirements
- R1: After reset both history stores are zero. Every counter sits at weakly not-taken: 1 for the 2-bit tables and 3 for the 3-bit table. So for any PC, pred_taken=0, pred_ghist=0 and pred_lhist=0.
- R2: Each accepted update (upd_valid=1) shifts upd_taken into bit 0 of the 12-bit global history, which is shown on pred_ghist. Bit i therefore holds the outcome of the (i+1)-th most recent update, with 1 meaning taken.
- R3: The local history store has 1024 untagged 10-bit entries selected by PC bits [11:2]. Two PCs that differ only outside those bits share an entry. An update shifts upd_taken into bit 0 of the entry selected by upd_pc, and pred_lhist shows the entry selected by pred_pc.
- R4: The global predictor has 4096 2-bit counters indexed by the global history (upd_ghist on update). It predicts taken when the counter is 2 or 3. It steps by one toward the outcome and saturates at 0 and 3.
- R5: The local predictor has 1024 3-bit counters indexed by the local history (upd_lhist on update). It predicts taken when the counter is 4 or more. It steps by one toward the outcome and saturates at 0 and 7.
- R6: The chooser has 4096 2-bit counters indexed by the global history. A value of 2 or more selects the global prediction; a lower value selects the local one. On update it changes only when the two component predictions at the saved indices differ. It steps toward 3 when the global predictor was the correct one and toward 0 when the local predictor was.
- R7: pred_taken is the component prediction that the chooser entry selects.
- R8: After a warm-up, a single branch that alternates taken/not-taken, or that follows a loop pattern of three taken and one not-taken, is predicted with no misses.
- R9: A cycle with upd_valid=0 changes no state, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | PC to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_ghist | output | 12 | Global history used for this prediction |
| pred_lhist | output | 10 | Local history used for this prediction |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_ghist | input | 12 | Global history saved at prediction |
| upd_lhist | input | 10 | Local history saved at prediction |

## Verification
The bench pays most attention to the chooser. It trains only on disagreement. A design that trains it on every update, or in the wrong direction, drifts away from the bench's arithmetic model within a few branches and mispredicts the learned patterns. Counter saturation is reached on purpose by long runs of one outcome. A counter that wraps instead of saturating flips its prediction, and the step-by-step comparison catches it. Local-history aliasing is checked with two PCs that differ only above bit 11, and a neighbouring PC is checked for staying untouched. An indexing or tag error shows up directly on pred_lhist. Idle cycles carry junk on the update inputs and must leave every output unchanged.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  // One saturating step of an unsigned counter toward up/down.
  function automatic int unsigned ctr_step(int unsigned v, int unsigned maxv, logic up);
    if (up) return (v == maxv) ? v : v + 1;
    else    return (v == 0)    ? v : v - 1;
  endfunction

  // Shift a new outcome into bit 0 of a history word.
  function automatic int unsigned hist_push(int unsigned h, int unsigned w, logic b);
    int unsigned mask;
    mask = (32'd1 << w) - 1;
    return ((h << 1) | int'(b)) & mask;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2,
  localparam int DEPTH = 1 << IDX_W,
  localparam int MAXV  = (1 << CTR_W) - 1,
  localparam int INITV = (1 << (CTR_W - 1)) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output logic [CTR_W-1:0] wr_old,
  output logic [CTR_W-1:0] wr_new
);
  import tourn_pkg::*;

  logic [CTR_W-1:0] mem [DEPTH];

  assign rd_val = mem[rd_idx];
  assign wr_old = mem[wr_idx];
  assign wr_new = wr_en ? CTR_W'(ctr_step(int'(wr_old), MAXV, wr_up)) : wr_old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_W'(INITV);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  import tourn_pkg::*;

  logic [HIST_W-1:0] mem [DEPTH];
  logic [HIST_W-1:0] shifted;

  assign rd_hist = mem[rd_idx];
  assign shifted = HIST_W'(hist_push(int'(mem[wr_idx]), HIST_W, wr_bit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= shifted;
    end
  end
endmodule

// File: rtl/tourn_predictor.sv
module tourn_predictor #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12,
  parameter int LHIST_W = 10,
  parameter int LIDX_W  = 10,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int CHO_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    pred_pc,
  output logic               pred_taken,
  output logic [GHIST_W-1:0] pred_ghist,
  output logic [LHIST_W-1:0] pred_lhist,
  input  logic               upd_valid,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               upd_taken,
  input  logic [GHIST_W-1:0] upd_ghist,
  input  logic [LHIST_W-1:0] upd_lhist
);
  import tourn_pkg::*;

  localparam int PC_LO = 2;
  localparam int PC_HI = LIDX_W + PC_LO - 1;

  // Named internal events, used by the checker.
  logic [GHIST_W-1:0] ghist_q;
  logic [LIDX_W-1:0]  pred_lidx, upd_lidx;
  logic [GCTR_W-1:0]  g_rd, g_upd_old, g_upd_new;
  logic [LCTR_W-1:0]  l_rd, l_upd_old, l_upd_new;
  logic [CHO_W-1:0]   c_rd, c_upd_old, c_upd_new;
  logic [LCTR_W-1:0]  l_unused_rd;
  logic               glob_pred, loc_pred, use_glob;
  logic               glob_upd_pred, loc_upd_pred;
  logic               chooser_we, chooser_up;

  assign pred_lidx = pred_pc[PC_HI:PC_LO];
  assign upd_lidx  = upd_pc[PC_HI:PC_LO];

  // Global history register
  always_ff @(posedge clk) begin
    if (!rst_n) ghist_q <= '0;
    else if (upd_valid) ghist_q <= GHIST_W'(hist_push(int'(ghist_q), GHIST_W, upd_taken));
  end

  tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_lidx), .rd_hist(pred_lhist),
    .wr_en(upd_valid), .wr_idx(upd_lidx), .wr_bit(upd_taken)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) u_gctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist_q), .rd_val(g_rd),
    .wr_en(upd_valid), .wr_idx(upd_ghist), .wr_up(upd_taken),
    .wr_old(g_upd_old), .wr_new(g_upd_new)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) u_lctr (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(pred_lhist), .rd_val(l_rd),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken),
    .wr_old(l_upd_old), .wr_new(l_upd_new)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CHO_W)) u_cho (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(ghist_q), .rd_val(c_rd),
    .wr_en(chooser_we), .wr_idx(upd_ghist), .wr_up(chooser_up),
    .wr_old(c_upd_old), .wr_new(c_upd_new)
  );

  assign l_unused_rd = '0;

  // Predict path
  assign glob_pred  = g_rd[GCTR_W-1];
  assign loc_pred   = l_rd[LCTR_W-1];
  assign use_glob   = c_rd[CHO_W-1];
  assign pred_taken = use_glob ? glob_pred : loc_pred;
  assign pred_ghist = ghist_q;

  // Chooser training: only on disagreement, toward the correct side
  assign glob_upd_pred = g_upd_old[GCTR_W-1];
  assign loc_upd_pred  = l_upd_old[LCTR_W-1];
  assign chooser_we    = upd_valid && (glob_upd_pred != loc_upd_pred);
  assign chooser_up    = (glob_upd_pred == upd_taken);
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int GHIST_W = 12,
  parameter int GCTR_W  = 2,
  parameter int LCTR_W  = 3,
  parameter int CHO_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] ghist_q,
  input logic [GCTR_W-1:0]  g_upd_old,
  input logic [GCTR_W-1:0]  g_upd_new,
  input logic [LCTR_W-1:0]  l_upd_old,
  input logic [LCTR_W-1:0]  l_upd_new,
  input logic [CHO_W-1:0]   c_upd_old,
  input logic [CHO_W-1:0]   c_upd_new,
  input logic               glob_upd_pred,
  input logic               loc_upd_pred
);
  localparam logic [GCTR_W-1:0] GMAX = '1;
  localparam logic [LCTR_W-1:0] LZERO = '0;

  // R1
  ghist_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ghist_q == '0);

  // R2
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist_q == {$past(ghist_q[GHIST_W-2:0]), $past(upd_taken)});

  // R9
  ghist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist_q));

  // R4
  gctr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && g_upd_old == GMAX) |-> g_upd_new == GMAX);

  // R4
  gctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (g_upd_new == g_upd_old) || (g_upd_new == g_upd_old + 1'b1)
                  || (g_upd_new == g_upd_old - 1'b1));

  // R5
  lctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && l_upd_old == LZERO) |-> l_upd_new == LZERO);

  // R6
  chooser_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_upd_new != c_upd_old) |-> (glob_upd_pred != loc_upd_pred));
endmodule

bind tourn_predictor tp_checker #(
  .GHIST_W(GHIST_W), .GCTR_W(GCTR_W), .LCTR_W(LCTR_W), .CHO_W(CHO_W)
) chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .ghist_q(ghist_q), .g_upd_old(g_upd_old), .g_upd_new(g_upd_new),
  .l_upd_old(l_upd_old), .l_upd_new(l_upd_new),
  .c_upd_old(c_upd_old), .c_upd_new(c_upd_new),
  .glob_upd_pred(glob_upd_pred), .loc_upd_pred(loc_upd_pred)
);

// File: tb/tourn_predictor_test.sv
module tourn_predictor_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pred_pc = 0;
  logic        pred_taken;
  logic [11:0] pred_ghist;
  logic [9:0]  pred_lhist;
  logic        upd_valid = 0;
  logic [31:0] upd_pc = 0;
  logic        upd_taken = 0;
  logic [11:0] upd_ghist = 0;
  logic [9:0]  upd_lhist = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state, kept as plain integers
  int gtab [4096];
  int ctab [4096];
  int ltab [1024];
  int lhst [1024];
  int ghr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourn_predictor uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin gtab[i] = 1; ctab[i] = 1; end
    for (int i = 0; i < 1024; i++) begin ltab[i] = 3; lhst[i] = 0; end
    ghr = 0;
  endtask

  function automatic int slot(logic [31:0] pc);
    return int'(pc / 4) % 1024;
  endfunction

  function automatic int model_guess(logic [31:0] pc);
    int lh = lhst[slot(pc)];
    int g  = (gtab[ghr] > 1) ? 1 : 0;
    int l  = (ltab[lh] > 3) ? 1 : 0;
    return (ctab[ghr] > 1) ? g : l;
  endfunction

  function automatic int toward(int v, int top, bit up);
    if (up) return (v < top) ? v + 1 : top;
    return (v > 0) ? v - 1 : 0;
  endfunction

  task automatic model_train(logic [31:0] pc, bit t, int gh, int lh);
    bit g = gtab[gh] > 1;
    bit l = ltab[lh] > 3;
    if (g != l) ctab[gh] = toward(ctab[gh], 3, g == t);
    gtab[gh] = toward(gtab[gh], 3, t);
    ltab[lh] = toward(ltab[lh], 7, t);
    lhst[slot(pc)] = (lhst[slot(pc)] * 2 + int'(t)) % 1024;
    ghr = (ghr * 2 + int'(t)) % 4096;
  endtask

  // One branch: predict, compare with model, then apply its update.
  task automatic branch(logic [31:0] pc, bit t, string req, output bit hit);
    int gh, lh;
    @(negedge clk);
    upd_valid = 0;
    pred_pc = pc;
    #1;
    gh = ghr; lh = lhst[slot(pc)];
    check({req, " taken"}, int'(pred_taken), model_guess(pc));
    check("R2 ghist", int'(pred_ghist), gh);
    check("R3 lhist", int'(pred_lhist), lh);
    hit = (pred_taken == t);
    upd_valid = 1; upd_pc = pc; upd_taken = t;
    upd_ghist = 12'(gh); upd_lhist = 10'(lh);
    @(posedge clk);
    model_train(pc, t, gh, lh);
  endtask

  task automatic idle_probe(logic [31:0] pc);
    @(negedge clk);
    upd_valid = 0;
    upd_pc = 32'hDEAD_BEE0; upd_taken = 1; upd_ghist = 12'hFFF; upd_lhist = 10'h3FF;
    pred_pc = pc;
    @(posedge clk);
    #1;
    check("R9 idle taken", int'(pred_taken), model_guess(pc));
    check("R9 idle ghist", int'(pred_ghist), ghr);
    check("R9 idle lhist", int'(pred_lhist), lhst[slot(pc)]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; upd_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    int misses;
    bit hit;
    logic [15:0] lfsr;
    do_reset();

    // R1 reset state across a spread of PCs
    for (int k = 0; k < 8; k++) begin
      pred_pc = 32'(k * 516);
      #1;
      check("R1 taken", int'(pred_taken), 0);
      check("R1 ghist", int'(pred_ghist), 0);
      check("R1 lhist", int'(pred_lhist), 0);
    end

    // R2/R3 explicit shifting and aliasing: outcomes 1,0,1 on 0x100
    branch(32'h100, 1, "R7", hit);
    branch(32'h100, 0, "R7", hit);
    branch(32'h100, 1, "R7", hit);
    @(negedge clk); upd_valid = 0;
    pred_pc = 32'h1100; #1;
    check("R3 alias lhist", int'(pred_lhist), 5);
    check("R2 ghist 101", int'(pred_ghist), 5);
    pred_pc = 32'h104; #1;
    check("R3 neighbour lhist", int'(pred_lhist), 0);

    // R9 idle cycles carry junk update fields
    for (int k = 0; k < 4; k++) idle_probe(32'h100 + 32'(4 * k));

    // R4/R5 saturation: long taken run then long not-taken run
    for (int k = 0; k < 20; k++) branch(32'h200, 1, "R4", hit);
    for (int k = 0; k < 20; k++) branch(32'h200, 0, "R5", hit);

    // R8 alternating pattern
    do_reset();
    misses = 0;
    for (int k = 0; k < 200; k++) begin
      branch(32'h340, bit'(k % 2 == 0), "R6", hit);
      if (k >= 160 && !hit) misses++;
    end
    check("R8 alternating misses", misses, 0);

    // R8 loop pattern T T T N
    do_reset();
    misses = 0;
    for (int k = 0; k < 300; k++) begin
      branch(32'h7A0, bit'(k % 4 != 3), "R6", hit);
      if (k >= 240 && !hit) misses++;
    end
    check("R8 loop misses", misses, 0);

    // R6/R7 mixed branches with pseudo-random outcomes, compared step by step
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      branch(32'(lfsr[3:0]) * 32'h404, (k % 5 == 0) ? lfsr[7] : bit'(lfsr[2:0] != 0), "R7", hit);
      if (k % 500 == 0) idle_probe(32'(k));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
    end
  end
endmodule